// File: doc/BRIEF.md
# Bus Master Tenure Timer

This block times how long a bus master may keep the bus once it has started a burst. It watches two pins: the master's own frame strobe, which the master drives, and the grant line from the arbiter. When the frame strobe goes from low to high, a new period of bus ownership begins. At that moment the block loads a programmed tenure length into a down-counter. The counter then drops by one on every clock and stops at zero.

The master engine reads two outputs. The expired output tells it that the guaranteed tenure has run out. The release request tells it that it must give up the bus now. If grant is withdrawn while the counter is still nonzero, the master keeps bursting. It must release only once grant is low and the counter has reached zero. If grant stays high, the burst may go on past zero.

The tenure length is held in a small register inside the block. Software writes it through a plain write strobe. Its two low bits always read as zero, so a tenure is always a multiple of four clocks. A hard reset clears everything, including this register. A soft reset clears only the timing state and leaves the programmed length alone. All pins are plain control and status signals: nothing flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `bmlt_timer`

## Requirements
- R1: While the hard reset `rst_n` is low, `count` is 0 and `expired` and `must_release` are low. The hard reset also clears the stored tenure length, so the first tenure after a hard reset loads 0.
- R2: A clock edge with `lat_we` high stores `lat_wdata` with bits [1:0] forced to 0. All 64 programmable values are kept exactly as written in bits [7:2].
- R3: A clock edge where `frame` is sampled high, and was sampled low at the previous edge, loads `count` with the stored tenure length.
- R4: At each later edge with `frame` still high, a nonzero `count` drops by exactly 1. A zero `count` stays at 0 and does not wrap.
- R5: While `frame` stays high, `count` is never reloaded, even after it has reached 0.
- R6: Any edge where `frame` is sampled low leaves `count` at 0 and `expired` low.
- R7: `expired` is high exactly when `count` is 0 and `frame` was sampled high at the last edge.
- R8: `must_release` equals `frame` AND NOT `gnt` AND `expired`. Losing grant while `count` is nonzero does not raise it, and it stays low whenever `gnt` is high.
- R9: A soft reset (`soft_rst` high at an edge) clears `count` and `expired` and ends the current tenure. It keeps the stored length, and if `frame` is still high afterwards, the next edge starts a new tenure that loads that same length.
- R10: A write to the tenure length during a tenure does not change the running `count`. The new length takes effect at the next tenure start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| lat_we | input | 1 | Write strobe for the tenure length |
| lat_wdata | input | 8 | Tenure length to store; bits [1:0] are ignored |
| frame | input | 1 | The master's own frame strobe, active high |
| gnt | input | 1 | Grant from the arbiter, active high |
| count | output | 8 | Current value of the tenure counter |
| expired | output | 1 | High when the guaranteed tenure has run out |
| must_release | output | 1 | The master must give up the bus now |

## Verification
The checker module tests the following on every cycle:
- a load on each frame rising edge;
- a drop of one, or a hold at zero, while frame stays high;
- clearing whenever frame is low or a soft reset is applied;
- that a release request only ever comes with frame high, grant low and a zero count;
- that a soft reset leaves the stored length untouched.

Some behaviour only the bench scenarios can show:
- that every programmable length reaches the counter with its low bits cleared;
- that loss of grant at each point in a tenure gives a release request at the right cycle;
- that a write in mid-tenure acts only on the next tenure;
- that a hard reset zeroes the stored length.

// File: rtl/bmlt_pkg.sv
package bmlt_pkg;
  localparam int unsigned LAT_W_DEF     = 8;
  localparam int unsigned FIXED_LSB_DEF = 2;

  function automatic logic [LAT_W_DEF-1:0] keep_mask(input int unsigned fixed_lsb);
    logic [LAT_W_DEF-1:0] m;
    for (int i = 0; i < LAT_W_DEF; i++) m[i] = (i >= fixed_lsb);
    return m;
  endfunction
endpackage

// File: rtl/bmlt_lat_reg.sv
module bmlt_lat_reg #(
  parameter int unsigned LAT_W     = bmlt_pkg::LAT_W_DEF,
  parameter int unsigned FIXED_LSB = bmlt_pkg::FIXED_LSB_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LAT_W-1:0] wdata,
  output logic [LAT_W-1:0] lat_q
);
  logic [LAT_W-1:0] wval;

  generate
    if (FIXED_LSB == 0) begin : g_full
      assign wval = wdata;
    end else begin : g_masked
      assign wval = {wdata[LAT_W-1:FIXED_LSB], {FIXED_LSB{1'b0}}};
    end
  endgenerate

  // Only the hard reset clears the stored length; the soft reset never reaches here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lat_q <= '0;
    else if (we) lat_q <= wval;
  end
endmodule

// File: rtl/bmlt_tenure_cnt.sv
module bmlt_tenure_cnt #(
  parameter int unsigned LAT_W = bmlt_pkg::LAT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             frame,
  input  logic [LAT_W-1:0] lat_val,
  output logic [LAT_W-1:0] count,
  output logic             tenure,
  output logic             cnt_zero
);
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             frame_q;
  logic             start;

  assign start = frame && !frame_q;

  always_comb begin
    if (!frame)             cnt_d = '0;
    else if (start)         cnt_d = lat_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else if (soft_rst) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      frame_q <= frame;
    end
  end

  assign count    = cnt_q;
  assign tenure   = frame_q;
  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/bmlt_release.sv
module bmlt_release (
  input  logic tenure,
  input  logic cnt_zero,
  input  logic frame,
  input  logic gnt,
  output logic expired,
  output logic must_release
);
  assign expired      = tenure && cnt_zero;
  assign must_release = frame && !gnt && expired;
endmodule

// File: rtl/bmlt_timer.sv
module bmlt_timer #(
  parameter int unsigned LAT_W     = bmlt_pkg::LAT_W_DEF,
  parameter int unsigned FIXED_LSB = bmlt_pkg::FIXED_LSB_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             lat_we,
  input  logic [LAT_W-1:0] lat_wdata,
  input  logic             frame,
  input  logic             gnt,
  output logic [LAT_W-1:0] count,
  output logic             expired,
  output logic             must_release
);
  logic [LAT_W-1:0] lat_q;
  logic             tenure_q;
  logic             cnt_zero;

  bmlt_lat_reg #(.LAT_W(LAT_W), .FIXED_LSB(FIXED_LSB)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .wdata(lat_wdata), .lat_q(lat_q)
  );

  bmlt_tenure_cnt #(.LAT_W(LAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame(frame),
    .lat_val(lat_q), .count(count), .tenure(tenure_q), .cnt_zero(cnt_zero)
  );

  bmlt_release u_rel (
    .tenure(tenure_q), .cnt_zero(cnt_zero), .frame(frame), .gnt(gnt),
    .expired(expired), .must_release(must_release)
  );
endmodule

// File: rtl/bmlt_timer_chk.sv
module bmlt_timer_chk #(
  parameter int unsigned LAT_W = bmlt_pkg::LAT_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             lat_we,
  input logic             frame,
  input logic             gnt,
  input logic [LAT_W-1:0] count,
  input logic             expired,
  input logic             must_release,
  input logic             tenure_q,
  input logic [LAT_W-1:0] lat_q
);
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && frame && !tenure_q) |=> (count == $past(lat_q)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && frame && tenure_q && count != '0) |=> (count == $past(count) - 1'b1));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && frame && tenure_q && count == '0) |=> (count == '0));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame || soft_rst) |=> (count == '0 && !expired));

  a_r8_release_cond: assert property (@(posedge clk) disable iff (!rst_n)
    must_release |-> (frame && !gnt && count == '0));

  a_r8_gnt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> !must_release);

  a_r9_soft_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !lat_we) |=> $stable(lat_q));
endmodule

bind bmlt_timer bmlt_timer_chk #(.LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .lat_we(lat_we),
  .frame(frame), .gnt(gnt), .count(count), .expired(expired),
  .must_release(must_release), .tenure_q(tenure_q), .lat_q(lat_q)
);

// File: tb/bmlt_timer_bench.sv
module bmlt_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       lat_we = 1'b0;
  logic [7:0] lat_wdata = '0;
  logic       frame = 1'b0;
  logic       gnt = 1'b1;
  logic [7:0] count;
  logic       expired;
  logic       must_release;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bmlt_timer u_bmlt_timer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .lat_we(lat_we),
    .lat_wdata(lat_wdata), .frame(frame), .gnt(gnt), .count(count),
    .expired(expired), .must_release(must_release)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req, int ec, int ee, int er);
    #1;
    chk({req, " count"}, count, ec);
    chk({req, " expired"}, expired, ee);
    chk({req, " must_release"}, must_release, er);
  endtask

  initial begin
    // R1: reset state
    frame = 1'b1; gnt = 1'b0;
    #3;
    chk_all("R1", 0, 0, 0);
    repeat (2) tick();
    chk_all("R1", 0, 0, 0);
    frame = 1'b0; gnt = 1'b1;
    tick();
    rst_n = 1'b1;
    tick();

    // Sweep every write value: R2 R3 R4 R5 R7 R8 R10
    for (int v = 0; v < 256; v++) begin
      int len;
      int gdrop;
      len   = v & 8'hFC;
      gdrop = ((v % 3) == 0) ? 100000 : (v % 11);
      lat_we = 1'b1; lat_wdata = 8'(v);
      tick();
      lat_we = 1'b0;
      frame = 1'b1; gnt = 1'b1;
      chk_all("R6 pre-start", 0, 0, 0);
      tick(); // load edge
      for (int n = 0; n <= len + 2; n++) begin
        int ec;
        int ee;
        ec = (n >= len) ? 0 : len - n;
        ee = (ec == 0) ? 1 : 0;
        gnt = (n < gdrop) ? 1'b1 : 1'b0;
        // R10: mid-tenure write must not disturb the count
        if (n == 1) begin
          lat_we = 1'b1; lat_wdata = 8'(~v);
        end else begin
          lat_we = 1'b0;
        end
        chk_all((n == 0) ? "R2 R3 load" : "R4 R5 R7 R8 R10", ec, ee,
                (ee == 1 && gnt == 1'b0) ? 1 : 0);
        tick();
      end
      lat_we = 1'b0;
      gnt = 1'b0;
      frame = 1'b0;
      #1;
      chk("R8 frame low", must_release, 0);
      tick();
      chk_all("R6 frame drop", 0, 0, 0);
      gnt = 1'b1;
    end

    // R10: the mid-tenure write (~255 -> 0) applies to the next tenure
    frame = 1'b1;
    tick();
    chk_all("R10 next tenure", 0, 1, 0);
    frame = 1'b0;
    tick();

    // R9: soft reset keeps the stored length
    lat_we = 1'b1; lat_wdata = 8'd43;
    tick();
    lat_we = 1'b0;
    frame = 1'b1;
    tick();
    chk_all("R9 load", 40, 0, 0);
    repeat (5) tick();
    chk_all("R9 run", 35, 0, 0);
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk_all("R9 soft clear", 0, 0, 0);
    tick();
    chk_all("R9 reload", 40, 0, 0);
    tick();
    chk_all("R9 run2", 39, 0, 0);

    // R1: hard reset clears the stored length
    rst_n = 1'b0;
    #1;
    chk_all("R1 async", 0, 0, 0);
    tick();
    rst_n = 1'b1;
    frame = 1'b0;
    tick();
    frame = 1'b1;
    tick();
    chk_all("R1 len cleared", 0, 1, 0);
    gnt = 1'b0;
    chk_all("R8 release", 0, 1, 1);
    frame = 1'b0;
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule